// File: doc/BRIEF.md
# ADC Code to Voltage Display

This block turns 12-bit conversion results from an external analog channel sequencer into a decimal voltage reading on a bank of seven-segment digits. Three slide-switch bits pick one of six analog channels. The block registers that choice, clamps it to a legal channel, and hands the channel number to the sequencer. It then watches the sequencer's result stream: a valid strobe, a channel tag and a 12-bit code.

When a valid result carries the selected channel's tag, the code is scaled to millivolts at the connector. The converter spans 0 to 2.5 V and the front end halves the connector voltage, so the block computes (code × 5000) >> 12. A sequential shift-add-3 converter turns that value into BCD. The result is shown in the form X.XXX volts, with active-low segments. The two digits that are not used stay dark.

Top module: `adc_volt_display`

## Requirements
- R1: After reset the display reads 0.000 and `ch_sel` is 0.
- R2: `ch_sel` takes the value of `sel_sw` one clock later. Switch values 6 and 7 give channel 5, so `ch_sel` never exceeds 5.
- R3: The shown value changes only on a cycle with `smp_valid` high and `smp_chan` equal to `ch_sel`. Results tagged for another channel, and switch changes with no matching result, leave the display as it was.
- R4: The shown value in millivolts is (`smp_code` × 5000) >> 12, which lies in the range 0 to 4998.
- R5: The digit fields are `seg_n[8*i +: 8]`. Digit 3 shows volts, digit 2 tenths, digit 1 hundredths and digit 0 thousandths (millivolts). Within a field, bit 0 is segment a through bit 6 segment g, bit 7 is the point, and all of them are active low. Digit patterns are ordered as gfedcba, with a 1 meaning the segment is lit: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F.
- R6: Only digit 3 has its point lit. Digits 4 and 5 have all eight bits at 1.
- R7: A new value appears exactly 13 clock edges after the edge that accepts the matching result, and not before.
- R8: A matching result that arrives while a conversion is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_sw | input | 3 | Channel choice from the switches |
| ch_sel | output | 3 | Clamped channel number sent to the sequencer |
| smp_valid | input | 1 | Result strobe from the sequencer |
| smp_chan | input | 3 | Channel tag of the result |
| smp_code | input | 12 | Conversion code |
| seg_n | output | 48 | Active-low segments, 8 bits per digit |

## Verification
The assertions assume that `smp_code` and `smp_chan` are driven to known values whenever `smp_valid` is high. They also assume that results for the chosen channel normally arrive spaced wider than one conversion. The stimulus therefore holds all inputs at defined values from time zero. It waits out each conversion before the next matching result, except in the one directed test that deliberately sends two results back to back to show the second one being dropped.

// File: rtl/adc_disp_pkg.sv
package adc_disp_pkg;
   typedef logic [3:0] bcd_t;

   localparam int SEG_W = 8;

   // Lit-segment pattern, bit0 = a .. bit6 = g, 1 = lit
   function automatic logic [6:0] glyph_on(input bcd_t d);
      case (d)
         4'd0: glyph_on = 7'h3F;
         4'd1: glyph_on = 7'h06;
         4'd2: glyph_on = 7'h5B;
         4'd3: glyph_on = 7'h4F;
         4'd4: glyph_on = 7'h66;
         4'd5: glyph_on = 7'h6D;
         4'd6: glyph_on = 7'h7D;
         4'd7: glyph_on = 7'h07;
         4'd8: glyph_on = 7'h7F;
         4'd9: glyph_on = 7'h6F;
         default: glyph_on = 7'h00;
      endcase
   endfunction

   // Number of decimal digits needed for values below lim
   function automatic int dec_digits(input int lim);
      int n;
      int v;
      n = 1;
      v = 10;
      while (v < lim) begin
         n = n + 1;
         v = v * 10;
      end
      return n;
   endfunction
endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
   parameter int SEL_W  = 3,
   parameter int NUM_CH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_sw,
   output logic [SEL_W-1:0] ch_sel
);
   localparam logic [SEL_W-1:0] TOP_CH = SEL_W'(NUM_CH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) ch_sel <= '0;
      else        ch_sel <= (sel_sw > TOP_CH) ? TOP_CH : sel_sw;
   end

   // R2: the channel handed to the sequencer stays inside the legal set
   p_chan_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ch_sel <= TOP_CH);
endmodule

// File: rtl/adc_mv_scale.sv
module adc_mv_scale #(
   parameter int CODE_W  = 12,
   parameter int FULL_MV = 5000,
   parameter int MV_W    = 13
) (
   input  logic [CODE_W-1:0] code,
   output logic [MV_W-1:0]   mv
);
   localparam int PROD_W = CODE_W + MV_W;

   logic [PROD_W-1:0] prod;

   always_comb begin
      prod = PROD_W'(code) * PROD_W'(FULL_MV);
      mv   = prod[CODE_W +: MV_W];
   end
endmodule

// File: rtl/adc_bcd_seq.sv
module adc_bcd_seq #(
   parameter int BIN_W = 13,
   parameter int NDIG  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BIN_W-1:0]  bin,
   output logic              busy,
   output logic [NDIG*4-1:0] bcd_out
);
   localparam int SR_W  = NDIG * 4 + BIN_W;
   localparam int CNT_W = $clog2(BIN_W + 1);

   logic [SR_W-1:0]  sr;
   logic [SR_W-1:0]  sr_adj;
   logic [SR_W-1:0]  sr_nxt;
   logic [CNT_W-1:0] cnt;

   always_comb begin
      sr_adj = sr;
      for (int i = 0; i < NDIG; i++) begin
         if (sr[BIN_W + 4*i +: 4] >= 4'd5)
            sr_adj[BIN_W + 4*i +: 4] = sr[BIN_W + 4*i +: 4] + 4'd3;
      end
      sr_nxt = {sr_adj[SR_W-2:0], 1'b0};
   end

   assign busy = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr      <= '0;
         cnt     <= '0;
         bcd_out <= '0;
      end else if (cnt == '0) begin
         if (start) begin
            sr  <= {{(NDIG*4){1'b0}}, bin};
            cnt <= CNT_W'(BIN_W);
         end
      end else begin
         sr  <= sr_nxt;
         cnt <= cnt - 1'b1;
         if (cnt == CNT_W'(1)) bcd_out <= sr_nxt[SR_W-1 -: NDIG*4];
      end
   end

   // R8: once running, a conversion steps down without being restarted
   p_busy_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (cnt == $past(cnt) - 1'b1));

   generate
      for (genvar d = 0; d < NDIG; d++) begin : g_dchk
         // R5: every produced digit is a decimal digit
         p_bcd_digit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            bcd_out[4*d +: 4] <= 4'd9);
      end
   endgenerate
endmodule

// File: rtl/adc_seg_drive.sv
module adc_seg_drive
   import adc_disp_pkg::*;
#(
   parameter int NDIG      = 4,
   parameter int DIGITS    = 6,
   parameter int POINT_POS = 3
) (
   input  logic [NDIG*4-1:0]       bcd,
   output logic [DIGITS*SEG_W-1:0] seg_n
);
   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_dig
         if (i < NDIG) begin : g_live
            localparam logic PT_OFF = (i == POINT_POS) ? 1'b0 : 1'b1;
            assign seg_n[SEG_W*i +: SEG_W] = {PT_OFF, ~glyph_on(bcd[4*i +: 4])};
         end else begin : g_dark
            assign seg_n[SEG_W*i +: SEG_W] = {SEG_W{1'b1}};
         end
      end
   endgenerate
endmodule

// File: rtl/adc_volt_display.sv
module adc_volt_display
   import adc_disp_pkg::*;
#(
   parameter int CODE_W  = 12,
   parameter int FULL_MV = 5000,
   parameter int NUM_CH  = 6,
   parameter int SEL_W   = 3,
   parameter int DIGITS  = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [SEL_W-1:0]        sel_sw,
   output logic [SEL_W-1:0]        ch_sel,
   input  logic                    smp_valid,
   input  logic [SEL_W-1:0]        smp_chan,
   input  logic [CODE_W-1:0]       smp_code,
   output logic [DIGITS*SEG_W-1:0] seg_n
);
   localparam int MV_W = $clog2(FULL_MV);
   localparam int NDIG = dec_digits(FULL_MV);

   generate
      if (NUM_CH < 1 || NUM_CH > (1 << SEL_W))
         $error("NUM_CH does not fit SEL_W");
      if (DIGITS < NDIG)
         $error("DIGITS too small for FULL_MV");
      if (CODE_W < 1)
         $error("CODE_W must be positive");
   endgenerate

   logic [MV_W-1:0]   mv;
   logic              start;
   logic              busy;
   logic [NDIG*4-1:0] bcd;

   adc_chan_pick #(.SEL_W(SEL_W), .NUM_CH(NUM_CH)) u_pick (
      .clk(clk), .rst_n(rst_n), .sel_sw(sel_sw), .ch_sel(ch_sel));

   adc_mv_scale #(.CODE_W(CODE_W), .FULL_MV(FULL_MV), .MV_W(MV_W)) u_scale (
      .code(smp_code), .mv(mv));

   assign start = smp_valid && (smp_chan == ch_sel);

   adc_bcd_seq #(.BIN_W(MV_W), .NDIG(NDIG)) u_bcd (
      .clk(clk), .rst_n(rst_n), .start(start), .bin(mv),
      .busy(busy), .bcd_out(bcd));

   adc_seg_drive #(.NDIG(NDIG), .DIGITS(DIGITS), .POINT_POS(NDIG-1)) u_seg (
      .bcd(bcd), .seg_n(seg_n));

   // R4: scaled millivolts stay under full scale
   p_mv_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> (mv < MV_W'(FULL_MV)));

   // R3: with no conversion running, the display holds
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(seg_n));
endmodule

// File: tb/sim_adc_volt_display.sv
module sim_adc_volt_display;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [2:0]  sel;
      logic [2:0]  chan;
      logic [11:0] code;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 3'd0, 12'd0},
      '{3'd1, 3'd1, 12'd4095},
      '{3'd2, 3'd2, 12'd2048},
      '{3'd3, 3'd3, 12'd1},
      '{3'd4, 3'd4, 12'd819},
      '{3'd5, 3'd5, 12'd820},
      '{3'd6, 3'd5, 12'd3000},
      '{3'd7, 3'd5, 12'd1234},
      '{3'd2, 3'd3, 12'd4000},
      '{3'd7, 3'd4, 12'd100},
      '{3'd0, 3'd0, 12'd3333}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  sel_sw = '0;
   logic [2:0]  ch_sel;
   logic        smp_valid = 1'b0;
   logic [2:0]  smp_chan = '0;
   logic [11:0] smp_code = '0;
   logic [47:0] seg_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int exp_mv = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_volt_display u0 (
      .clk(clk), .rst_n(rst_n), .sel_sw(sel_sw), .ch_sel(ch_sel),
      .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_code(smp_code),
      .seg_n(seg_n));

   function automatic logic [7:0] pat(input int d);
      case (d)
         0: pat = 8'hC0; 1: pat = 8'hF9; 2: pat = 8'hA4; 3: pat = 8'hB0;
         4: pat = 8'h99; 5: pat = 8'h92; 6: pat = 8'h82; 7: pat = 8'hF8;
         8: pat = 8'h80; default: pat = 8'h90;
      endcase
   endfunction

   function automatic logic [47:0] exp_seg(input int mv);
      logic [47:0] s;
      s[7:0]   = pat(mv % 10);
      s[15:8]  = pat((mv / 10) % 10);
      s[23:16] = pat((mv / 100) % 10);
      s[31:24] = pat((mv / 1000) % 10) & 8'h7F;
      s[47:32] = 16'hFFFF;
      return s;
   endfunction

   function automatic int scale(input int code);
      return (code * 5000) >> 12;
   endfunction

   function automatic int clamp(input int s);
      return (s > 5) ? 5 : s;
   endfunction

   task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic [2:0] ch, input logic [11:0] code);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_chan  = ch;
      smp_code  = code;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset display", seg_n, exp_seg(0));
      chk("R1 reset channel", {45'd0, ch_sel}, 48'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         int old_mv;
         sel_sw = VECS[i].sel;
         @(negedge clk);
         @(negedge clk);
         chk("R2 channel clamp", {45'd0, ch_sel}, 48'(clamp(VECS[i].sel)));
         old_mv = exp_mv;
         if (int'(VECS[i].chan) == clamp(VECS[i].sel))
            exp_mv = scale(VECS[i].code);
         pulse(VECS[i].chan, VECS[i].code);
         repeat (12) @(negedge clk);
         chk("R7 not yet updated", seg_n, exp_seg(old_mv));
         @(negedge clk);
         chk("R3 R4 R5 value", seg_n, exp_seg(exp_mv));
      end

      // R6: point and blank digits
      chk("R6 dark digits", {32'd0, seg_n[47:32]}, 48'h0000_0000_FFFF);
      chk("R6 point bits", {44'd0, seg_n[31], seg_n[23], seg_n[15], seg_n[7]}, 48'h7);

      // R8: back-to-back matching results, second dropped
      sel_sw = 3'd1;
      repeat (3) @(negedge clk);
      @(negedge clk);
      smp_valid = 1'b1; smp_chan = 3'd1; smp_code = 12'd2048;
      @(negedge clk);
      smp_code = 12'd100;
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (20) @(negedge clk);
      exp_mv = 2500;
      chk("R8 busy result dropped", seg_n, exp_seg(exp_mv));

      // R3: switch change without a result keeps the display
      sel_sw = 3'd4;
      repeat (20) @(negedge clk);
      chk("R3 switch change holds", seg_n, exp_seg(exp_mv));
      chk("R2 sel 4 passes", {45'd0, ch_sel}, 48'd4);

      // R4: full-scale code after idle
      pulse(3'd4, 12'd4095);
      repeat (14) @(negedge clk);
      chk("R4 full scale", seg_n, exp_seg(4998));

      finish_run();
   end
endmodule